// File: doc/BRIEF.md
# Word-Addressed Burst Memory Slave

This block is a memory endpoint on a five-channel valid/ready bus. It holds a small array of 32-bit words and serves both single-beat and incrementing-burst transfers in each direction. A write starts with an address and beat count on the write-address channel. The data beats then arrive on the write-data channel, and the block closes the transfer with a write response. A read starts with an address and beat count on the read-address channel, and the block then streams the words back.

Two independent state machines run the transfers, one for writes and one for reads. Each one picks a single-beat path or a burst path from the length field when the address is accepted. The write machine moves WR_IDLE → WR_SINGLE (length 0) or WR_BURST (length above 0). From either of those it moves → WR_RESP on the beat that carries the last flag, and → WR_IDLE once the response is taken. The read machine moves RD_IDLE → RD_SINGLE (length 0) or RD_BURST (length above 0). It returns → RD_IDLE when the final beat is taken. In RD_SINGLE that final beat is the only beat. In RD_BURST the final beat is the one where the remaining-beat down-counter reads 1, and this counter also drives the last flag.

Words are indexed by the address bits just above the two-bit byte offset, so a byte address A selects word (A >> 2) mod 256. Each burst beat moves to the next word.

Top module: `axi_mem_slave`

## Requirements
- R1: `awready` is high only while the write machine is idle. An accepted write address selects the single path (`awlen` = 0) or the burst path (`awlen` > 0). In either path `wready` is high, and it is low while `awready` is high.
- R2: Beat k of a write (counting from 0) is stored at word index ((`awaddr` >> 2) + k) mod 256.
- R3: A beat accepted with `wvalid` and `wlast` both high ends the data phase. From the next cycle `wready` is low and `bvalid` is high.
- R4: While `bvalid` is high, `bresp` is 2'b00 (OKAY). `bvalid` stays high until `bready` is seen high. On the cycle after that, `bvalid` is low and `awready` is high.
- R5: `arready` is high only while the read machine is idle. A read with `arlen` = 0 returns exactly one beat, and that beat has `rlast` = 1.
- R6: A read with `arlen` = N > 0 returns N+1 beats from words ((`araddr` >> 2) + k) mod 256, with `rlast` high only on the final beat.
- R7: While `rvalid` is high and `rready` is low, `rvalid`, `rdata` and `rlast` hold, and the burst position does not advance.
- R8: `rresp` is 2'b00 (OKAY) whenever `rvalid` is high.
- R9: After reset `bvalid`, `rvalid` and `wready` are low and both address-ready outputs are high.
- R10: The read and write machines run independently. A read burst and a write burst to different words may be in flight at the same time, and both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | 32 | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wlast | input | 1 | Final write beat |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | 32 | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |

## Verification
A write-data beat can be stored in the same cycle that a read beat is delivered from a different word, so the two state machines and the memory's write and read ports are all active at once. The bench provokes this by launching a write burst to one region and a read burst from another region in parallel. The read burst has stalls placed on some beats. Every read beat is judged against words written earlier. The newly written region is then read back afterwards, so a corrupted or misplaced concurrent write shows up as a data mismatch.

// File: rtl/axim_pkg.sv
package axim_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SINGLE,
        WR_BURST,
        WR_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SINGLE,
        RD_BURST
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axim_store.sv
module axim_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdat,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdat
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[widx] <= wdat;
        end
    end

    // Combinational read: the word under the read pointer is presented directly.
    assign rdat = words[ridx];

endmodule

// File: rtl/axim_wr_ctrl.sv
module axim_wr_ctrl
    import axim_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  aw_idx,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_last,
    input  logic              w_valid,
    output logic              w_ready,
    output logic [1:0]        b_resp,
    output logic              b_valid,
    input  logic              b_ready,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_data
);

    wr_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_valid) begin
                    idx_d   = aw_idx;
                    state_d = (aw_len == '0) ? WR_SINGLE : WR_BURST;
                end
            end
            WR_SINGLE: begin
                if (w_valid && w_last) begin
                    state_d = WR_RESP;
                end
            end
            WR_BURST: begin
                if (w_valid) begin
                    idx_d = idx_q + 1'b1;
                    if (w_last) begin
                        state_d = WR_RESP;
                    end
                end
            end
            WR_RESP: begin
                if (b_ready) begin
                    state_d = WR_IDLE;
                end
            end
            default: state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        aw_ready = 1'b0;
        w_ready  = 1'b0;
        b_valid  = 1'b0;
        b_resp   = RESP_OKAY;
        mem_we   = 1'b0;
        mem_idx  = idx_q;
        mem_data = w_data;
        unique case (state_q)
            WR_IDLE:   aw_ready = 1'b1;
            WR_SINGLE: begin
                w_ready = 1'b1;
                mem_we  = w_valid;
            end
            WR_BURST: begin
                w_ready = 1'b1;
                mem_we  = w_valid;
            end
            WR_RESP:   b_valid = 1'b1;
            default:   aw_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/axim_rd_ctrl.sv
module axim_rd_ctrl
    import axim_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int IDX_W = 8,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ar_idx,
    input  logic [LEN_W-1:0] ar_len,
    input  logic             ar_valid,
    output logic             ar_ready,
    output logic [1:0]       r_resp,
    output logic             r_last,
    output logic             r_valid,
    input  logic             r_ready,
    output logic [IDX_W-1:0] mem_idx
);

    rd_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             final_beat;

    assign final_beat = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            idx_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        left_d  = left_q;
        unique case (state_q)
            RD_IDLE: begin
                if (ar_valid) begin
                    idx_d   = ar_idx;
                    left_d  = CNT_W'(ar_len) + CNT_W'(1);
                    state_d = (ar_len == '0) ? RD_SINGLE : RD_BURST;
                end
            end
            RD_SINGLE: begin
                if (r_ready) begin
                    left_d  = '0;
                    state_d = RD_IDLE;
                end
            end
            RD_BURST: begin
                if (r_ready) begin
                    left_d = left_q - CNT_W'(1);
                    idx_d  = idx_q + 1'b1;
                    if (final_beat) begin
                        state_d = RD_IDLE;
                    end
                end
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        ar_ready = 1'b0;
        r_valid  = 1'b0;
        r_last   = 1'b0;
        r_resp   = RESP_OKAY;
        mem_idx  = idx_q;
        unique case (state_q)
            RD_IDLE:   ar_ready = 1'b1;
            RD_SINGLE: begin
                r_valid = 1'b1;
                r_last  = 1'b1;
            end
            RD_BURST: begin
                r_valid = 1'b1;
                r_last  = final_beat;
            end
            default:   ar_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/axi_mem_slave.sv
module axi_mem_slave #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 256,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int BYTE_OFF = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [LEN_W-1:0]  awlen,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wlast,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [LEN_W-1:0]  arlen,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast,
    output logic              rvalid,
    input  logic              rready
);

    logic [IDX_W-1:0]  aw_idx, ar_idx, wr_idx, rd_idx;
    logic              wr_en;
    logic [DATA_W-1:0] wr_word;
    logic              unused_addr_bits;

    assign aw_idx = awaddr[BYTE_OFF +: IDX_W];
    assign ar_idx = araddr[BYTE_OFF +: IDX_W];
    assign unused_addr_bits = ^{awaddr[ADDR_W-1:BYTE_OFF+IDX_W], awaddr[BYTE_OFF-1:0],
                                araddr[ADDR_W-1:BYTE_OFF+IDX_W], araddr[BYTE_OFF-1:0]};

    axim_wr_ctrl #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W)
    ) wr_ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_idx   (aw_idx),
        .aw_len   (awlen),
        .aw_valid (awvalid),
        .aw_ready (awready),
        .w_data   (wdata),
        .w_last   (wlast),
        .w_valid  (wvalid),
        .w_ready  (wready),
        .b_resp   (bresp),
        .b_valid  (bvalid),
        .b_ready  (bready),
        .mem_we   (wr_en),
        .mem_idx  (wr_idx),
        .mem_data (wr_word)
    );

    axim_rd_ctrl #(
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) rd_ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_idx   (ar_idx),
        .ar_len   (arlen),
        .ar_valid (arvalid),
        .ar_ready (arready),
        .r_resp   (rresp),
        .r_last   (rlast),
        .r_valid  (rvalid),
        .r_ready  (rready),
        .mem_idx  (rd_idx)
    );

    axim_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk  (clk),
        .we   (wr_en),
        .widx (wr_idx),
        .wdat (wr_word),
        .ridx (rd_idx),
        .rdat (rdata)
    );

endmodule

// File: rtl/axim_checker.sv
module axim_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awvalid,
    input logic              awready,
    input logic              wready,
    input logic              wvalid,
    input logic              wlast,
    input logic [1:0]        bresp,
    input logic              bvalid,
    input logic              bready,
    input logic              arvalid,
    input logic              arready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rlast,
    input logic              rvalid,
    input logic              rready
);

    AST_AW_TAKEN_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready) |=> (!awready && wready)); // R1

    AST_AW_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        awready |-> !wready); // R1

    AST_LAST_BEAT_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && wlast) |=> (bvalid && !wready)); // R3

    AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00)); // R4

    AST_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid); // R4

    AST_B_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && bready) |=> (!bvalid && awready)); // R4

    AST_AR_TAKEN_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> (!arready && rvalid)); // R5

    AST_R_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> (!rvalid && arready)); // R6

    AST_R_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast))); // R7

    AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == 2'b00)); // R8

    AST_AR_R_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        arready |-> !rvalid); // R5

endmodule

bind axi_mem_slave axim_checker #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .awvalid (awvalid),
    .awready (awready),
    .wready  (wready),
    .wvalid  (wvalid),
    .wlast   (wlast),
    .bresp   (bresp),
    .bvalid  (bvalid),
    .bready  (bready),
    .arvalid (arvalid),
    .arready (arready),
    .rdata   (rdata),
    .rresp   (rresp),
    .rlast   (rlast),
    .rvalid  (rvalid),
    .rready  (rready)
);

// File: tb/axi_mem_slave_tb.sv
module axi_mem_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] awaddr = '0;
    logic [7:0]  awlen = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic        wlast = 1'b0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [31:0] araddr = '0;
    logic [7:0]  arlen = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rlast;
    logic        rvalid;
    logic        rready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    axi_mem_slave dut_i (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awlen(awlen), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arlen(arlen), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Write transfer; gap_mask bit k inserts one idle cycle before beat k.
    task automatic do_write(input logic [31:0] addr, input int len, input logic [31:0] seed,
                            input logic [31:0] gap_mask, input int bdelay);
        awaddr  = addr;
        awlen   = 8'(len);
        awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        check("R1", "awready low after address", {31'b0, awready}, 32'd0);
        for (int k = 0; k <= len; k++) begin
            if (gap_mask[k % 32]) begin
                wvalid = 1'b0;
                @(negedge clk);
            end
            wdata  = seed + 32'(k) * 32'h0101_0011;
            wlast  = (k == len);
            wvalid = 1'b1;
            check("R1", "wready during data", {31'b0, wready}, 32'd1);
            model[8'((addr >> 2) + 32'(k))] = wdata;
            @(negedge clk);
        end
        wvalid = 1'b0;
        wlast  = 1'b0;
        check("R3", "wready low after last", {31'b0, wready}, 32'd0);
        check("R3", "bvalid after last", {31'b0, bvalid}, 32'd1);
        for (int d = 0; d < bdelay; d++) begin
            @(negedge clk);
            check("R4", "bvalid held", {31'b0, bvalid}, 32'd1);
        end
        check("R4", "bresp okay", {30'b0, bresp}, 32'd0);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        check("R4", "bvalid low after response", {31'b0, bvalid}, 32'd0);
        check("R4", "awready back", {31'b0, awready}, 32'd1);
    endtask

    // Read transfer; stall_mask bit k holds rready low for two cycles at beat k.
    task automatic do_read(input string req, input logic [31:0] addr, input int len,
                           input logic [31:0] stall_mask);
        logic [31:0] held;
        araddr  = addr;
        arlen   = 8'(len);
        arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        check("R5", "arready low after address", {31'b0, arready}, 32'd0);
        for (int k = 0; k <= len; k++) begin
            if (stall_mask[k % 32]) begin
                rready = 1'b0;
                held = rdata;
                @(negedge clk);
                @(negedge clk);
                check("R7", "rvalid held in stall", {31'b0, rvalid}, 32'd1);
                check("R7", "rdata held in stall", rdata, held);
            end
            check(req, "rvalid", {31'b0, rvalid}, 32'd1);
            check(req, "rdata", rdata, model[8'((addr >> 2) + 32'(k))]);
            check(req, "rlast", {31'b0, rlast}, {31'b0, k == len});
            check("R8", "rresp okay", {30'b0, rresp}, 32'd0);
            rready = 1'b1;
            @(negedge clk);
        end
        rready = 1'b0;
        check(req, "rvalid low after last", {31'b0, rvalid}, 32'd0);
        check(req, "arready back", {31'b0, arready}, 32'd1);
    endtask

    task automatic t_reset;
        check("R9", "awready", {31'b0, awready}, 32'd1);
        check("R9", "arready", {31'b0, arready}, 32'd1);
        check("R9", "bvalid", {31'b0, bvalid}, 32'd0);
        check("R9", "rvalid", {31'b0, rvalid}, 32'd0);
        check("R9", "wready", {31'b0, wready}, 32'd0);
    endtask

    task automatic t_single;
        do_write(32'h0000_0024, 0, 32'hCAFE_0001, 32'h0, 0);
        do_read("R5", 32'h0000_0024, 0, 32'h0);
        do_write(32'h0000_0030, 0, 32'h1234_5678, 32'h0, 3);
        do_read("R5", 32'h0000_0030, 0, 32'h1);
    endtask

    task automatic t_burst;
        do_write(32'h0000_0100, 7, 32'hA000_0000, 32'h0000_0014, 1);
        do_read("R6", 32'h0000_0100, 7, 32'h0);
        do_read("R6", 32'h0000_0108, 3, 32'h0);
    endtask

    task automatic t_stall;
        do_read("R7", 32'h0000_0100, 7, 32'h0000_0089);
    endtask

    task automatic t_wrap;
        // Word index 254 with four beats lands on 254, 255, 0, 1 (R2).
        do_write(32'h0000_03F8, 3, 32'h5EED_0000, 32'h0, 0);
        do_read("R2", 32'h0000_03F8, 3, 32'h0);
        do_read("R2", 32'h0000_0000, 1, 32'h0);
    endtask

    task automatic t_concurrent;
        do_write(32'h0000_0200, 5, 32'hB000_0000, 32'h0, 0);
        fork
            do_write(32'h0000_0300, 6, 32'hC000_0000, 32'h0000_0002, 2);
            do_read("R10", 32'h0000_0200, 5, 32'h0000_0004);
        join
        do_read("R10", 32'h0000_0300, 6, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_stall();
        t_wrap();
        t_concurrent();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule